// File: doc/BRIEF.md
# Integer ALU with Overflow Flag

This block is the integer arithmetic/logic stage of a simple RISC datapath. Each cycle it takes two operands, an operation code, a signed/unsigned qualifier and an optional immediate. One clock edge later it presents a result, a flag that marks an all-zero result, and a flag that marks signed overflow. Branch-equal and branch-not-equal logic can use the zero flag directly. The surrounding pipeline reads the overflow flag and decides for itself whether to trap; the ALU only reports it.

The second operand is either the register operand or an immediate widened to the data width. The operation class picks how the immediate is widened. Add, subtract and the less-than comparison sign-extend it. AND, OR, XOR and NOR zero-extend it. Subtraction is done on the shared adder by inverting the second operand and forcing carry-in to 1. The less-than comparison reuses that subtraction: the signed form takes the sign of the difference corrected by the overflow term, and the unsigned form takes the inverted carry-out. The comparison result lands in bit 0 and every other bit is zero.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the registered outputs become `res_q` = 0, `zero_q` = 1 and `ovf_q` = 0.
- R2: Outputs change only at a rising edge, and they reflect the inputs sampled at that edge. There is exactly one cycle of latency.
- R3: `op_sel` 0 (add) gives (A + B) mod 2^DW, and `op_sel` 1 (subtract) gives (A − B) mod 2^DW, whatever the value of `sgn`.
- R4: `op_sel` 2, 3, 4 and 5 give bitwise AND, OR, XOR and NOR (~(A|B)) of the two operands.
- R5: `op_sel` 6 (less-than) puts 1 in bit 0 when A < B and 0 otherwise, with all upper bits zero. The comparison is two's-complement when `sgn` = 1 and unsigned when `sgn` = 0.
- R6: `zero_q` is 1 exactly when `res_q` is all zeros, for every operation.
- R7: With `sgn` = 1 and an add or subtract, `ovf_q` is 1 exactly when the true signed result does not fit in DW bits. An add of operands with differing signs never overflows. A subtract of operands with equal signs never overflows.
- R8: `ovf_q` stays 0 when `sgn` = 0, and for every operation other than add and subtract.
- R9: With `use_imm` = 1, the second operand is `imm` widened to DW bits: sign-extended for `op_sel` 0, 1 and 6, zero-extended for `op_sel` 2 to 5. `opb` is then ignored.
- R10: `op_sel` 7 is reserved. It gives `res_q` = 0 and `ovf_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 less-than, 7 reserved) |
| sgn | input | 1 | 1 = signed interpretation, 0 = unsigned |
| use_imm | input | 1 | 1 = second operand taken from the extended immediate |
| opa | input | DW | First operand |
| opb | input | DW | Second register operand |
| imm | input | IW | Immediate field |
| res_q | output | DW | Registered result |
| zero_q | output | 1 | Registered all-zero result flag |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The bench sweeps a 6-bit configuration exhaustively. It covers every operand pair under every operation code and both qualifier values, then every immediate under every operation. Each expected value comes from integer arithmetic.

The sweep reaches the most-negative and most-positive operands, where overflow is easy to get wrong:
- A flag that ignored the qualifier or the operation would show overflow on unsigned or logic operations.
- A flag that used the wrong sign terms for subtraction would fire on equal-sign differences.
- A less-than that skipped the overflow correction would invert its answer whenever the difference wraps.
- A less-than that used the signed path for unsigned compares would fail on operands with the top bit set.

Immediates with the top bit set expose an extension that is chosen by the wrong operation class. Changing the inputs mid-cycle shows any combinational leak to the outputs.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_NOR = 3'd5,
    OP_SLT = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm,
  input  logic          zext,
  output logic [DW-1:0] wide
);
  localparam int PAD = (DW > IW) ? DW - IW : 1;

  generate
    if (DW > IW) begin : g_pad
      logic [PAD-1:0] fill;
      assign fill = zext ? '0 : {PAD{imm[IW-1]}};
      assign wide = {fill, imm};
    end else begin : g_trunc
      assign wide = imm[DW-1:0];
    end
  endgenerate
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic [DW:0]   full;

  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, sub};
  assign sum   = full[DW-1:0];
  assign cout  = full[DW];
  // both adder inputs share a sign and the sum's sign departs from it
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    fn,
  output logic [DW-1:0] y
);
  always_comb begin
    case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_sel,
  input  logic          sgn,
  input  logic          use_imm,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [IW-1:0] imm,
  output logic [DW-1:0] res_q,
  output logic          zero_q,
  output logic          ovf_q
);
  localparam int MSB = DW - 1;

  alu_op_e       op;
  logic          is_logic;
  logic          is_arith;
  logic          do_sub;
  logic [DW-1:0] imm_wide;
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] sum;
  logic          cout;
  logic          ovf_raw;
  logic [DW-1:0] logic_y;
  logic          less;
  logic [DW-1:0] res_d;
  logic          ovf_d;

  assign op       = alu_op_e'(op_sel);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);
  assign do_sub   = (op == OP_SUB) || (op == OP_SLT);

  alu_imm_ext #(.DW(DW), .IW(IW)) u_ext (
    .imm  (imm),
    .zext (is_logic),
    .wide (imm_wide)
  );

  assign opnd_b = use_imm ? imm_wide : opb;

  alu_addsub #(.DW(DW)) u_add (
    .a    (opa),
    .b    (opnd_b),
    .sub  (do_sub),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf_raw)
  );

  alu_logic #(.DW(DW)) u_log (
    .a  (opa),
    .b  (opnd_b),
    .fn (op_sel[1:0] - 2'd2),
    .y  (logic_y)
  );

  // signed: difference sign corrected by overflow; unsigned: borrow out
  assign less = sgn ? (sum[MSB] ^ ovf_raw) : ~cout;

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                 res_d = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:  res_d = logic_y;
      OP_SLT:                         res_d = {{(DW-1){1'b0}}, less};
      default:                        res_d = '0;
    endcase
  end

  assign ovf_d = sgn && is_arith && ovf_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b1;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= (res_d == '0);
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op_sel,
  input logic          sgn,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opnd_b,
  input logic [DW-1:0] res_q,
  input logic          zero_q,
  input logic          ovf_q
);
  localparam int MSB = DW - 1;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (res_q == '0) && zero_q && !ovf_q);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q == (res_q == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(sgn && (op_sel <= 3'd1)) |=> !ovf_q);

  // R7
  mixed_add_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd0 && opa[MSB] != opnd_b[MSB]) |=> !ovf_q);

  // R7
  same_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd1 && opa[MSB] == opnd_b[MSB]) |=> !ovf_q);

  // R5
  slt_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd6) |=> (res_q[DW-1:1] == '0));

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 3'd7) |=> (res_q == '0) && !ovf_q);
endmodule

bind int_alu int_alu_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .sgn    (sgn),
  .opa    (opa),
  .opnd_b (opnd_b),
  .res_q  (res_q),
  .zero_q (zero_q),
  .ovf_q  (ovf_q)
);

// File: tb/sim_int_alu.sv
`timescale 1ns/1ps
module sim_int_alu;
  localparam int DW = 6;
  localparam int IW = 3;
  localparam int M  = 1 << DW;
  localparam int H  = M / 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_sel;
  logic          sgn;
  logic          use_imm;
  logic [DW-1:0] opa;
  logic [DW-1:0] opb;
  logic [IW-1:0] imm;
  logic [DW-1:0] res_q;
  logic          zero_q;
  logic          ovf_q;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  int_alu #(.DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .sgn(sgn), .use_imm(use_imm),
    .opa(opa), .opb(opb), .imm(imm),
    .res_q(res_q), .zero_q(zero_q), .ovf_q(ovf_q)
  );

  function automatic int to_s(int v);
    return (v >= H) ? v - M : v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (op=%0d sgn=%0d imm_mode=%0d a=%0d b=%0d imm=%0d)",
               tag, act, exp, op_sel, sgn, use_imm, opa, opb, imm);
    end
  endtask

  task automatic apply(int op, int s, int ui, int a, int b, int im);
    int bv, sa, sb, r, ov, t;
    string rtag, otag;
    op_sel = op[2:0]; sgn = s[0]; use_imm = ui[0];
    opa = a[DW-1:0]; opb = b[DW-1:0]; imm = im[IW-1:0];
    if (ui != 0) begin
      if (op >= 2 && op <= 5) bv = im;                                      // R9 zero-extend
      else bv = (im >= (1 << (IW-1))) ? im + M - (1 << IW) : im;            // R9 sign-extend
    end else bv = b;
    sa = to_s(a); sb = to_s(bv); ov = 0;
    case (op)
      0: begin r = (a + bv) % M; t = sa + sb; ov = (s != 0 && (t >= H || t < -H)) ? 1 : 0; end
      1: begin r = (a - bv + M) % M; t = sa - sb; ov = (s != 0 && (t >= H || t < -H)) ? 1 : 0; end
      2: r = a & bv;
      3: r = a | bv;
      4: r = a ^ bv;
      5: r = (~(a | bv)) & (M - 1);
      6: r = (s != 0) ? ((sa < sb) ? 1 : 0) : ((a < bv) ? 1 : 0);
      default: r = 0;
    endcase
    if (ui != 0)                  rtag = "R9";
    else if (op <= 1)             rtag = "R3";
    else if (op <= 5)             rtag = "R4";
    else if (op == 6)             rtag = "R5";
    else                          rtag = "R10";
    otag = (s != 0 && op <= 1) ? "R7" : "R8";
    @(posedge clk);
    #1;
    check(rtag, int'(res_q), r);
    check("R6", int'(zero_q), (r == 0) ? 1 : 0);
    check(otag, int'(ovf_q), ov);
  endtask

  initial begin
    rst = 1'b1; op_sel = 3'd0; sgn = 1'b0; use_imm = 1'b0;
    opa = '0; opb = '0; imm = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", int'(res_q), 0);
    check("R1", int'(zero_q), 1);
    check("R1", int'(ovf_q), 0);
    rst = 1'b0;

    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < M; a++)
          for (int b = 0; b < M; b++)
            apply(op, s, 0, a, b, 0);

    for (int op = 0; op < 8; op++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < M; a++)
          for (int im = 0; im < (1 << IW); im++)
            apply(op, s, 1, a, (a * 7 + 3) % M, im);

    // R2: mid-cycle input change must not reach the outputs
    apply(0, 1, 0, 1, 1, 0);
    opa = 6'd5;
    #1;
    check("R2", int'(res_q), 2);
    @(posedge clk);
    #1;
    check("R2", int'(res_q), 6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2: watchdog expired, actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule